// File: doc/BRIEF.md
# Virtually indexed, physically tagged cache tag lookup

This block is the tag and lookup stage of a 32 KB, 4-way set-associative data cache with 32-byte lines. An access presents a 32-bit virtual address. The set is picked from virtual address bits 12..5. At the same time the upper virtual bits are sent out as a translation request. One cycle later the translated physical page number comes back. Its upper bits (physical address 31..13) are compared against the stored physical tags of every way in the chosen set. A registered hit/miss result, with the hitting way, appears in the cycle after that.

Bit 12 of the set index lies above the 4 KB page offset. Two virtual aliases of one physical line can therefore fall in different sets. The result reports this bit as the page colour, so aliasing can be seen at the ports. A fill request writes the physical tag of a line into a way of the set named by its virtual address. It uses the lowest invalid way, and a per-set round-robin pointer when the set is full. A mode input restricts both lookup and fill to way 0, so the cache acts as a direct-mapped one. An invalidate-all input empties the cache in one cycle.

Top module: `vipt_tag_lookup`

## Requirements
- R1: The set index is virtual address bits 12..5 (256 sets). Bits 4..0 do not affect the result, so two accesses that differ only there give the same hit and way.
- R2: The tag compared and stored is physical address bits 31..13 (xlat_ppn bits 19..1). Virtual bits 31..13 never take part: a lookup with different upper virtual bits but the same physical address and index hits. A lookup with a different physical tag misses.
- R3: A request sampled at clock edge t gets its translation on xlat_ppn during the cycle after t. rsp_valid is high for exactly one cycle, the one after edge t+1. xlat_req and xlat_vpn (virtual bits 31..12) follow req_valid and req_vaddr in the same cycle.
- R4: A way hits only when its valid bit is set and its tag matches. After reset every lookup misses, and rsp_valid and fill_ack are low.
- R5: On a hit, rsp_way gives the number (0..3) of the way holding the matching tag.
- R6: A fill writes the lowest-numbered invalid way of its set. fill_ack rises for one cycle after the fill edge, with fill_way giving the way written.
- R7: When all 4 ways of the set are valid, a fill takes the way named by that set's round-robin pointer. The pointer starts at 0 after reset and advances 0,1,2,3,0 only on such fills. Each set has its own pointer.
- R8: While dm_mode is 1, fills always write way 0 and lookups match only way 0. A valid matching tag in ways 1..3 reports a miss. Fills in this mode leave the round-robin pointer unchanged.
- R9: inv_all clears every valid bit at the next edge. A fill in the same cycle is dropped: nothing is written and fill_ack stays low.
- R10: rsp_colour equals virtual address bit 12 of the access. Two aliases of one physical line whose bit 12 differs use different sets, and both can be valid at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dm_mode | input | 1 | 1: lookup and fill use way 0 only |
| inv_all | input | 1 | Clear all valid bits |
| req_valid | input | 1 | Lookup request |
| req_vaddr | input | 32 | Virtual address of the lookup |
| xlat_req | output | 1 | Translation request |
| xlat_vpn | output | 20 | Virtual page number to translate |
| xlat_ppn | input | 20 | Physical page number, one cycle after request |
| rsp_valid | output | 1 | Lookup result valid |
| rsp_hit | output | 1 | 1 on hit |
| rsp_way | output | 2 | Hitting way |
| rsp_colour | output | 1 | Page colour (virtual bit 12) of the access |
| fill_valid | input | 1 | Fill request |
| fill_vaddr | input | 32 | Virtual address selecting the set to fill |
| fill_paddr | input | 32 | Physical address supplying the tag |
| fill_ack | output | 1 | Fill performed |
| fill_way | output | 2 | Way written by the fill |

## Verification
On every cycle the assertions check the following:
- the two-edge request-to-result timing;
- that at most one way is written at once;
- that direct-mapped mode only ever reports or fills way 0;
- that invalidate leaves no valid bit behind;
- that the round-robin pointer steps by one on each fill into a full set.

Only the bench's scenarios can show which way the tag comparison picks for a given physical address. The same goes for the order in which fills use free ways and then victims. Aliases that differ in bit 12 are shown living in two sets at once, and a drop to direct-mapped mode is shown to leave the per-set pointers untouched.

// File: rtl/vipt_tag_pkg.sv
package vipt_tag_pkg;
  localparam int unsigned VT_ADDR_W     = 32;
  localparam int unsigned VT_WAYS       = 4;
  localparam int unsigned VT_WAY_BYTES  = 8192;
  localparam int unsigned VT_LINE_BYTES = 32;
  localparam int unsigned VT_PAGE_BYTES = 4096;
endpackage

// File: rtl/vt_way_store.sv
module vt_way_store #(
  parameter int unsigned SETS  = 256,
  parameter int unsigned IDX_W = 8,
  parameter int unsigned TAG_W = 19
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inv_all,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [TAG_W-1:0] wr_tag,
  output logic             wr_set_valid,
  input  logic [IDX_W-1:0] lk_idx,
  output logic             lk_valid,
  output logic [TAG_W-1:0] lk_tag
);
  logic [SETS-1:0]  valid_q, valid_d;
  logic [TAG_W-1:0] tag_q [SETS];

  always_comb begin
    valid_d = valid_q;
    if (inv_all)    valid_d = '0;
    else if (wr_en) valid_d[wr_idx] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) valid_q <= '0;
    else        valid_q <= valid_d;
  end

  always_ff @(posedge clk) begin
    if (wr_en && !inv_all) tag_q[wr_idx] <= wr_tag;
  end

  assign wr_set_valid = valid_q[wr_idx];
  assign lk_valid     = valid_q[lk_idx];
  assign lk_tag       = tag_q[lk_idx];

  // R9: nothing survives an invalidate
  a_r9_inv_clears: assert property (@(posedge clk) disable iff (!rst_n)
    inv_all |=> (valid_q == '0));
endmodule

// File: rtl/vt_tag_compare.sv
module vt_tag_compare #(
  parameter int unsigned WAYS  = 4,
  parameter int unsigned TAG_W = 19,
  parameter int unsigned WAY_W = 2
) (
  input  logic                       dm_mode,
  input  logic [WAYS-1:0]            way_valid,
  input  logic [WAYS-1:0][TAG_W-1:0] way_tag,
  input  logic [TAG_W-1:0]           ptag,
  output logic                       hit,
  output logic [WAY_W-1:0]           hit_way
);
  logic [WAYS-1:0] match;

  for (genvar w = 0; w < WAYS; w++) begin : g_match
    if (w == 0) begin : g_w0
      assign match[w] = way_valid[w] && (way_tag[w] == ptag);
    end else begin : g_wn
      assign match[w] = !dm_mode && way_valid[w] && (way_tag[w] == ptag);
    end
  end

  always_comb begin
    hit_way = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (match[w]) hit_way = WAY_W'(w);
    end
  end

  assign hit = |match;
endmodule

// File: rtl/vt_victim_pick.sv
module vt_victim_pick #(
  parameter int unsigned WAYS  = 4,
  parameter int unsigned SETS  = 256,
  parameter int unsigned IDX_W = 8,
  parameter int unsigned WAY_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             dm_mode,
  input  logic             fill_en,
  input  logic [IDX_W-1:0] fill_idx,
  input  logic [WAYS-1:0]  set_valid,
  output logic [WAY_W-1:0] vict_way
);
  logic [SETS-1:0][WAY_W-1:0] rr_q, rr_d;
  logic                       free_found;
  logic [WAY_W-1:0]           free_way;
  logic                       set_full;

  always_comb begin
    free_found = 1'b0;
    free_way   = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (!set_valid[w]) begin
        free_found = 1'b1;
        free_way   = WAY_W'(w);
      end
    end
  end

  assign set_full = !free_found;

  always_comb begin
    if (dm_mode)         vict_way = '0;
    else if (free_found) vict_way = free_way;
    else                 vict_way = rr_q[fill_idx];
  end

  always_comb begin
    rr_d = rr_q;
    if (fill_en && !dm_mode && set_full)
      rr_d[fill_idx] = rr_q[fill_idx] + WAY_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rr_q <= '0;
    else        rr_q <= rr_d;
  end

  // R7: a fill into a full set moves that set's pointer on by one
  a_r7_rr_step: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_en && !dm_mode && set_full) |=>
      (rr_q[$past(fill_idx)] == $past(rr_q[fill_idx]) + WAY_W'(1)));
endmodule

// File: rtl/vipt_tag_lookup.sv
module vipt_tag_lookup
  import vipt_tag_pkg::*;
#(
  parameter int unsigned ADDR_W     = VT_ADDR_W,
  parameter int unsigned WAYS       = VT_WAYS,
  parameter int unsigned WAY_BYTES  = VT_WAY_BYTES,
  parameter int unsigned LINE_BYTES = VT_LINE_BYTES,
  parameter int unsigned PAGE_BYTES = VT_PAGE_BYTES,
  localparam int unsigned OFF_W   = $clog2(LINE_BYTES),
  localparam int unsigned TAG_LSB = $clog2(WAY_BYTES),
  localparam int unsigned PG_W    = $clog2(PAGE_BYTES),
  localparam int unsigned IDX_W   = TAG_LSB - OFF_W,
  localparam int unsigned SETS    = 1 << IDX_W,
  localparam int unsigned TAG_W   = ADDR_W - TAG_LSB,
  localparam int unsigned PPN_W   = ADDR_W - PG_W,
  localparam int unsigned COL_W   = TAG_LSB - PG_W,
  localparam int unsigned WAY_W   = $clog2(WAYS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              dm_mode,
  input  logic              inv_all,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_vaddr,
  output logic              xlat_req,
  output logic [PPN_W-1:0]  xlat_vpn,
  input  logic [PPN_W-1:0]  xlat_ppn,
  output logic              rsp_valid,
  output logic              rsp_hit,
  output logic [WAY_W-1:0]  rsp_way,
  output logic [COL_W-1:0]  rsp_colour,
  input  logic              fill_valid,
  input  logic [ADDR_W-1:0] fill_vaddr,
  input  logic [ADDR_W-1:0] fill_paddr,
  output logic              fill_ack,
  output logic [WAY_W-1:0]  fill_way
);
  // stage 1 (translation cycle) state
  logic             s1_valid_q, s1_valid_d;
  logic [IDX_W-1:0] s1_idx_q, s1_idx_d;
  logic [COL_W-1:0] s1_col_q, s1_col_d;

  logic [TAG_W-1:0] ptag;
  logic [TAG_W-1:0] fill_tag;
  logic [IDX_W-1:0] fill_idx;
  logic             fill_go;

  logic [WAYS-1:0]            way_we;
  logic [WAYS-1:0]            way_lk_valid;
  logic [WAYS-1:0][TAG_W-1:0] way_lk_tag;
  logic [WAYS-1:0]            way_fill_valid;
  logic [WAY_W-1:0]           vict_way;
  logic                       cmp_hit;
  logic [WAY_W-1:0]           cmp_way;
  logic                       unused_bits;

  assign xlat_req = req_valid;
  assign xlat_vpn = req_vaddr[ADDR_W-1:PG_W];
  assign ptag     = xlat_ppn[PPN_W-1:COL_W];
  assign fill_tag = fill_paddr[ADDR_W-1:TAG_LSB];
  assign fill_idx = fill_vaddr[TAG_LSB-1:OFF_W];
  assign fill_go  = fill_valid && !inv_all;

  assign unused_bits = ^{req_vaddr[OFF_W-1:0], fill_vaddr[ADDR_W-1:TAG_LSB],
                         fill_vaddr[OFF_W-1:0], fill_paddr[TAG_LSB-1:0],
                         xlat_ppn[COL_W-1:0]};

  // stage 1 next state
  always_comb begin
    s1_valid_d = req_valid;
    s1_idx_d   = s1_idx_q;
    s1_col_d   = s1_col_q;
    if (req_valid) begin
      s1_idx_d = req_vaddr[TAG_LSB-1:OFF_W];
      s1_col_d = req_vaddr[TAG_LSB-1:PG_W];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_valid_q <= 1'b0;
      s1_idx_q   <= '0;
      s1_col_q   <= '0;
    end else begin
      s1_valid_q <= s1_valid_d;
      s1_idx_q   <= s1_idx_d;
      s1_col_q   <= s1_col_d;
    end
  end

  for (genvar w = 0; w < WAYS; w++) begin : g_way
    assign way_we[w] = fill_go && (vict_way == WAY_W'(w));
    vt_way_store #(.SETS(SETS), .IDX_W(IDX_W), .TAG_W(TAG_W)) i_store (
      .clk          (clk),
      .rst_n        (rst_n),
      .inv_all      (inv_all),
      .wr_en        (way_we[w]),
      .wr_idx       (fill_idx),
      .wr_tag       (fill_tag),
      .wr_set_valid (way_fill_valid[w]),
      .lk_idx       (s1_idx_q),
      .lk_valid     (way_lk_valid[w]),
      .lk_tag       (way_lk_tag[w])
    );
  end

  vt_tag_compare #(.WAYS(WAYS), .TAG_W(TAG_W), .WAY_W(WAY_W)) i_cmp (
    .dm_mode   (dm_mode),
    .way_valid (way_lk_valid),
    .way_tag   (way_lk_tag),
    .ptag      (ptag),
    .hit       (cmp_hit),
    .hit_way   (cmp_way)
  );

  vt_victim_pick #(.WAYS(WAYS), .SETS(SETS), .IDX_W(IDX_W), .WAY_W(WAY_W)) i_vict (
    .clk       (clk),
    .rst_n     (rst_n),
    .dm_mode   (dm_mode),
    .fill_en   (fill_go),
    .fill_idx  (fill_idx),
    .set_valid (way_fill_valid),
    .vict_way  (vict_way)
  );

  // result registers, loaded under their own enables
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid  <= 1'b0;
      rsp_hit    <= 1'b0;
      rsp_way    <= '0;
      rsp_colour <= '0;
      fill_ack   <= 1'b0;
      fill_way   <= '0;
    end else begin
      rsp_valid <= s1_valid_q;
      fill_ack  <= fill_go;
      if (s1_valid_q) begin
        rsp_hit    <= cmp_hit;
        rsp_way    <= cmp_way;
        rsp_colour <= s1_col_q;
      end
      if (fill_go) fill_way <= vict_way;
    end
  end

  // R3: a request yields exactly one result two edges later
  a_r3_rsp_latency: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> ##1 rsp_valid);
  a_r3_rsp_source: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $past(req_valid, 2));
  // R6: a fill writes at most one way
  a_r6_one_writer: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(way_we));
  // R8: direct-mapped mode confines hits and fills to way 0
  a_r8_dm_hit_way0: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_hit && $past(dm_mode)) |-> (rsp_way == '0));
  a_r8_dm_fill_way0: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_valid && !inv_all && dm_mode) |=> (fill_ack && fill_way == '0));
endmodule

// File: tb/test_vipt_tag_lookup.sv
module test_vipt_tag_lookup;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 18;

  typedef struct packed {
    logic        is_fill;
    logic [31:0] va;
    logic [31:0] pa;
    logic        exp_hit;
    logic [1:0]  exp_way;
    logic        exp_col;
    logic [7:0]  req;
  } vec_t;

  // is_fill, va, pa, exp_hit, exp_way (fill way or hit way), exp_col, requirement
  localparam vec_t VECS [NVEC] = '{
    '{1'b0, 32'h0000_1040, 32'h8000_0040, 1'b0, 2'd0, 1'b1, 8'd4},  // R4 empty
    '{1'b1, 32'h0000_1040, 32'h8000_0040, 1'b0, 2'd0, 1'b0, 8'd6},  // R6 first free
    '{1'b0, 32'h0000_1044, 32'h8000_0044, 1'b1, 2'd0, 1'b1, 8'd1},  // R1 offset
    '{1'b0, 32'h7000_1040, 32'h8000_0040, 1'b1, 2'd0, 1'b1, 8'd2},  // R2 upper VA
    '{1'b0, 32'h0000_1040, 32'h9000_0040, 1'b0, 2'd0, 1'b1, 8'd2},  // R2 new PA
    '{1'b1, 32'h0000_1040, 32'h9000_0040, 1'b0, 2'd1, 1'b0, 8'd6},
    '{1'b1, 32'h0000_1040, 32'hA000_0040, 1'b0, 2'd2, 1'b0, 8'd6},
    '{1'b1, 32'h0000_1040, 32'hB000_0040, 1'b0, 2'd3, 1'b0, 8'd6},
    '{1'b0, 32'h0000_1040, 32'hB000_0040, 1'b1, 2'd3, 1'b1, 8'd5},  // R5
    '{1'b1, 32'h0000_1040, 32'hC000_0040, 1'b0, 2'd0, 1'b0, 8'd7},  // R7 victim 0
    '{1'b0, 32'h0000_1040, 32'h8000_0040, 1'b0, 2'd0, 1'b1, 8'd7},
    '{1'b0, 32'h0000_1040, 32'hC000_0040, 1'b1, 2'd0, 1'b1, 8'd7},
    '{1'b1, 32'h0000_1040, 32'hD000_0040, 1'b0, 2'd1, 1'b0, 8'd7},  // R7 victim 1
    '{1'b0, 32'h0000_0040, 32'hA000_0040, 1'b0, 2'd0, 1'b0, 8'd10}, // R10 alias
    '{1'b1, 32'h0000_0040, 32'hA000_0040, 1'b0, 2'd0, 1'b0, 8'd10},
    '{1'b0, 32'h0000_0040, 32'hA000_0040, 1'b1, 2'd0, 1'b0, 8'd10},
    '{1'b0, 32'h0000_1040, 32'hA000_0040, 1'b1, 2'd2, 1'b1, 8'd10},
    '{1'b1, 32'h0000_1060, 32'h8000_0060, 1'b0, 2'd0, 1'b0, 8'd7}   // R7 own set
  };

  logic        clk, rst_n, dm_mode, inv_all, req_valid, fill_valid;
  logic [31:0] req_vaddr, fill_vaddr, fill_paddr;
  logic        xlat_req;
  logic [19:0] xlat_vpn, xlat_ppn;
  logic        rsp_valid, rsp_hit, rsp_colour, fill_ack;
  logic [1:0]  rsp_way, fill_way;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  vipt_tag_lookup i_vipt_tag_lookup (
    .clk, .rst_n, .dm_mode, .inv_all, .req_valid, .req_vaddr,
    .xlat_req, .xlat_vpn, .xlat_ppn, .rsp_valid, .rsp_hit, .rsp_way,
    .rsp_colour, .fill_valid, .fill_vaddr, .fill_paddr, .fill_ack, .fill_way
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic look(input logic [31:0] va, input logic [31:0] pa, input logic dm,
                      input logic eh, input logic [1:0] ew, input logic ec, input string tag);
    @(negedge clk);
    req_valid = 1'b1; req_vaddr = va; dm_mode = dm;
    @(negedge clk);
    req_valid = 1'b0; xlat_ppn = pa[31:12];
    @(negedge clk);
    check({tag, " rsp_valid"}, 32'(rsp_valid), 32'd1);
    check({tag, " hit"}, 32'(rsp_hit), 32'(eh));
    if (eh) check({tag, " way"}, 32'(rsp_way), 32'(ew));
    check({tag, " colour"}, 32'(rsp_colour), 32'(ec));
  endtask

  task automatic fill(input logic [31:0] va, input logic [31:0] pa, input logic dm,
                      input logic [1:0] ew, input string tag);
    @(negedge clk);
    fill_valid = 1'b1; fill_vaddr = va; fill_paddr = pa; dm_mode = dm;
    @(negedge clk);
    fill_valid = 1'b0;
    check({tag, " fill_ack"}, 32'(fill_ack), 32'd1);
    check({tag, " fill_way"}, 32'(fill_way), 32'(ew));
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; dm_mode = 1'b0; inv_all = 1'b0; req_valid = 1'b0;
    fill_valid = 1'b0; req_vaddr = '0; fill_vaddr = '0; fill_paddr = '0; xlat_ppn = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R4: reset state
    check("R4 reset rsp_valid", 32'(rsp_valid), 32'd0);
    check("R4 reset fill_ack", 32'(fill_ack), 32'd0);

    for (int i = 0; i < NVEC; i++) begin
      string t;
      t = $sformatf("R%0d vec%0d", VECS[i].req, i);
      if (VECS[i].is_fill) fill(VECS[i].va, VECS[i].pa, 1'b0, VECS[i].exp_way, t);
      else look(VECS[i].va, VECS[i].pa, 1'b0, VECS[i].exp_hit, VECS[i].exp_way,
                VECS[i].exp_col, t);
    end

    // R3: translation request outputs and single-cycle result pulse
    @(negedge clk);
    req_valid = 1'b1; req_vaddr = 32'hABCD_1040;
    #1;
    check("R3 xlat_req", 32'(xlat_req), 32'd1);
    check("R3 xlat_vpn", 32'(xlat_vpn), 32'h000A_BCD1);
    @(negedge clk);
    req_valid = 1'b0; xlat_ppn = 20'hC0000;
    check("R3 rsp early", 32'(rsp_valid), 32'd0);
    @(negedge clk);
    check("R3 rsp on time", 32'(rsp_valid), 32'd1);
    check("R3 hit", 32'(rsp_hit), 32'd1);
    @(negedge clk);
    check("R3 rsp one cycle", 32'(rsp_valid), 32'd0);

    // R8: direct-mapped mode (set 0x82 holds C,D,A,B in ways 0..3)
    look(32'h0000_1040, 32'hB000_0040, 1'b1, 1'b0, 2'd0, 1'b1, "R8 dm way3 ignored");
    fill(32'h0000_1040, 32'hE000_0040, 1'b1, 2'd0, "R8 dm fill");
    look(32'h0000_1040, 32'hE000_0040, 1'b1, 1'b1, 2'd0, 1'b1, "R8 dm hit");
    look(32'h0000_1040, 32'hD000_0040, 1'b0, 1'b1, 2'd1, 1'b1, "R8 back to 4 ways");
    fill(32'h0000_1040, 32'hF000_0040, 1'b0, 2'd2, "R7 R8 pointer kept");

    // R9: invalidate-all with a simultaneous fill
    @(negedge clk);
    inv_all = 1'b1; fill_valid = 1'b1; fill_vaddr = 32'h0000_1080; fill_paddr = 32'h8000_0080;
    @(negedge clk);
    inv_all = 1'b0; fill_valid = 1'b0;
    check("R9 fill dropped", 32'(fill_ack), 32'd0);
    look(32'h0000_1040, 32'hE000_0040, 1'b0, 1'b0, 2'd0, 1'b1, "R9 cleared");
    look(32'h0000_1080, 32'h8000_0080, 1'b0, 1'b0, 2'd0, 1'b1, "R9 no write");
    fill(32'h0000_1040, 32'hE000_0040, 1'b0, 2'd0, "R6 after invalidate");

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule